// File: doc/BRIEF.md
# Data Address Watchpoint Comparator

This block watches the data side of a processor pipeline for accesses that touch up to `NUM_CH` programmed address windows (two by default). Each channel holds a pair of 64-bit registers written through a single-cycle register-write port. The first register carries the watched address, which is always treated as a doubleword-aligned base. The second register holds the control bits: a 6-bit doubleword count, read and write enables, and one enable for each of the three privilege levels.

For every load or store presented on the access inputs, the block decides combinationally whether any channel matches. A match needs three things: the access byte range overlaps the channel window, the access direction is enabled, and the current privilege level is enabled. The result goes out as a per-channel hit vector and a combined stop request. The pipeline uses the stop request to hold the access before it takes effect.

Rewriting either register of a channel replaces that channel's match setup from the next cycle on. A combinational read port returns the stored register values unchanged.

Top module: `dwatch_cmp`

## Requirements
- R1: A synchronous active-high reset clears every address and control register to zero. While reset holds them at zero, no channel hits.
- R2: A write with `wr_en` high stores `wr_data` into the control register (`wr_ctrl`=1) or the address register (`wr_ctrl`=0) of channel `wr_sel`. The read port (`rd_sel`, `rd_ctrl`) shows the full stored value from the next cycle on, and the registers of other channels do not change.
- R3: The window base is the address register with its three least significant bits forced to zero (LSB-0 numbering), so address register bits [2:0] never affect matching.
- R4: The window length is (N+1)*8 bytes, where N is control bits [15:10] (LSB-0). The window covers [base, base+len).
- R5: A channel's address test passes when [acc_addr, acc_addr+acc_size) overlaps the window. Both ranges are computed without wrap-around past the top of the address space. An access with `acc_size`=0 never matches.
- R6: Control bit 6 enables matching on writes (`acc_write`=1), and control bit 5 enables matching on reads (`acc_write`=0). With both bits clear the channel never hits.
- R7: `acc_priv` encodes 0 = problem state, 1 = supervisor, 2 = hypervisor and 3 = reserved. These are enabled by control bits 0, 1 and 2 respectively. Level 3 never hits, and with all three bits clear the channel never hits.
- R8: Control bit 7 is stored and read back but has no effect on matching.
- R9: `hit[c]` is high in the same cycle as the access inputs when `acc_valid` is high and channel c passes R5–R7. `stop_before` is the OR of all hit bits. With `acc_valid` low, no hit is raised.
- R10: After a write to either register of a channel, matching from the next cycle on follows only the new value, and the previous setup no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Channel selected for the write |
| wr_ctrl | input | 1 | 1 writes the control register, 0 writes the address register |
| wr_data | input | ADDR_W | Write data |
| rd_sel | input | SEL_W | Channel selected for readback |
| rd_ctrl | input | 1 | 1 reads the control register, 0 reads the address register |
| rd_data | output | ADDR_W | Readback data |
| acc_valid | input | 1 | An access is presented |
| acc_addr | input | ADDR_W | First byte address of the access |
| acc_size | input | SIZE_W | Access size in bytes |
| acc_write | input | 1 | 1 for store, 0 for load |
| acc_priv | input | 2 | Current privilege level |
| hit | output | NUM_CH | Per-channel match |
| stop_before | output | 1 | Any channel matched; hold the access |

## Verification
The bench targets the edges of the window: the last byte inside it, the first byte past it, an access that starts below the base and straddles it, and a window that ends exactly at the top of the address space. An off-by-one length computation or a range sum that wraps would show up there as a missed or a spurious hit. Directed cases isolate each direction and each privilege enable, including the reserved privilege code, so that a swapped or misdecoded control bit gives a hit in the wrong case. Rewrites of live channels check that the old window stops matching in the very next cycle. Random configurations and near-window accesses compare the hit vector with a bench model on every access.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

   // Control register field positions (LSB-0); the decode depends on them.
   localparam int CTL_PR     = 0;
   localparam int CTL_SV     = 1;
   localparam int CTL_HV     = 2;
   localparam int CTL_RD     = 5;
   localparam int CTL_WR     = 6;
   localparam int CTL_RSV    = 7;
   localparam int CTL_CNT_LO = 10;
   localparam int CNT_W      = 6;
   localparam int ALIGN_BITS = 3;

   typedef enum logic [1:0] {
      PRIV_USER = 2'd0,
      PRIV_SUP  = 2'd1,
      PRIV_HYP  = 2'd2,
      PRIV_RSVD = 2'd3
   } priv_e;

   typedef struct packed {
      logic [CNT_W-1:0] cnt;
      logic             rd_en;
      logic             wr_en;
      logic             pr_en;
      logic             sv_en;
      logic             hv_en;
   } chan_cfg_t;

endpackage

// File: rtl/dwatch_chan_regs.sv
module dwatch_chan_regs #(
   parameter int ADDR_W = 64,
   parameter int SEL_W  = 1,
   parameter int MY_IDX = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_ctrl,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] addr_q,
   output logic [ADDR_W-1:0] ctrl_q
);

   logic mine;
   assign mine = wr_en && (wr_sel == SEL_W'(MY_IDX));

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         ctrl_q <= '0;
      end else if (mine) begin
         if (wr_ctrl) ctrl_q <= wr_data;
         else         addr_q <= wr_data;
      end
   end

   // R10: a control write replaces the setup on the next cycle
   p_rearm_ctrl_r10: assert property (@(posedge clk) disable iff (rst)
      (mine && wr_ctrl) |=> (ctrl_q == $past(wr_data)));
   // R10: an address write replaces the setup on the next cycle
   p_rearm_addr_r10: assert property (@(posedge clk) disable iff (rst)
      (mine && !wr_ctrl) |=> (addr_q == $past(wr_data)));
   // R2: registers of a channel not addressed stay unchanged
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !mine |=> ($stable(addr_q) && $stable(ctrl_q)));

endmodule

// File: rtl/dwatch_range.sv
module dwatch_range
   import dwatch_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int SIZE_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [SIZE_W-1:0] acc_size,
   output logic              overlap
);

   localparam int EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] win_lo, win_hi, acc_lo, acc_hi, win_len;

   always_comb begin
      win_len = (EXT_W'(cnt) + EXT_W'(1)) << ALIGN_BITS;
      win_lo  = {1'b0, base_addr};
      win_hi  = win_lo + win_len;
      acc_lo  = {1'b0, acc_addr};
      acc_hi  = acc_lo + EXT_W'(acc_size);
      overlap = (acc_size != '0) && (acc_lo < win_hi) && (win_lo < acc_hi);
   end

   // R5: an empty access never overlaps
   p_empty_access_r5: assert property (@(posedge clk) disable iff (rst)
      (acc_size == '0) |-> !overlap);

endmodule

// File: rtl/dwatch_qual.sv
module dwatch_qual
   import dwatch_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  chan_cfg_t  cfg,
   input  logic       overlap,
   input  logic       acc_valid,
   input  logic       acc_write,
   input  logic [1:0] acc_priv,
   output logic       hit
);

   logic dir_ok, priv_ok;

   always_comb begin
      dir_ok = acc_write ? cfg.wr_en : cfg.rd_en;
      unique case (priv_e'(acc_priv))
         PRIV_USER: priv_ok = cfg.pr_en;
         PRIV_SUP:  priv_ok = cfg.sv_en;
         PRIV_HYP:  priv_ok = cfg.hv_en;
         default:   priv_ok = 1'b0;
      endcase
      hit = acc_valid && overlap && dir_ok && priv_ok;
   end

   // R6: a hit on a store needs the write enable, on a load the read enable
   p_dir_wr_r6: assert property (@(posedge clk) disable iff (rst)
      (hit && acc_write) |-> cfg.wr_en);
   p_dir_rd_r6: assert property (@(posedge clk) disable iff (rst)
      (hit && !acc_write) |-> cfg.rd_en);
   // R7: no privilege enable, no hit
   p_priv_none_r7: assert property (@(posedge clk) disable iff (rst)
      !(cfg.pr_en || cfg.sv_en || cfg.hv_en) |-> !hit);
   // R9: no access, no hit
   p_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !acc_valid |-> !hit);
   // R5: a hit needs an address overlap
   p_need_overlap_r5: assert property (@(posedge clk) disable iff (rst)
      hit |-> overlap);

endmodule

// File: rtl/dwatch_cmp.sv
module dwatch_cmp
   import dwatch_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int NUM_CH = 2,
   parameter int SIZE_W = 4,
   localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_ctrl,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              rd_ctrl,
   output logic [ADDR_W-1:0] rd_data,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic              acc_write,
   input  logic [1:0]        acc_priv,
   output logic [NUM_CH-1:0] hit,
   output logic              stop_before
);

   initial begin
      assert (ADDR_W >= 16) else $error("ADDR_W must hold the control fields");
      assert (NUM_CH >= 1)  else $error("NUM_CH must be at least 1");
      assert (SIZE_W >= 1 && SIZE_W < ADDR_W) else $error("SIZE_W out of range");
   end

   logic [ADDR_W-1:0] addr_arr [NUM_CH];
   logic [ADDR_W-1:0] ctrl_arr [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [ADDR_W-1:0] addr_q, ctrl_q, base;
      chan_cfg_t         cfg;
      logic              ovl;

      dwatch_chan_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .MY_IDX(c)) u_regs (
         .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
         .wr_ctrl(wr_ctrl), .wr_data(wr_data),
         .addr_q(addr_q), .ctrl_q(ctrl_q));

      assign base      = {addr_q[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      assign cfg.cnt   = ctrl_q[CTL_CNT_LO +: CNT_W];
      assign cfg.rd_en = ctrl_q[CTL_RD];
      assign cfg.wr_en = ctrl_q[CTL_WR];
      assign cfg.pr_en = ctrl_q[CTL_PR];
      assign cfg.sv_en = ctrl_q[CTL_SV];
      assign cfg.hv_en = ctrl_q[CTL_HV];

      dwatch_range #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_rng (
         .clk(clk), .rst(rst), .base_addr(base), .cnt(cfg.cnt),
         .acc_addr(acc_addr), .acc_size(acc_size), .overlap(ovl));

      dwatch_qual u_qual (
         .clk(clk), .rst(rst), .cfg(cfg), .overlap(ovl),
         .acc_valid(acc_valid), .acc_write(acc_write),
         .acc_priv(acc_priv), .hit(hit[c]));

      assign addr_arr[c] = addr_q;
      assign ctrl_arr[c] = ctrl_q;
   end

   assign rd_data     = rd_ctrl ? ctrl_arr[rd_sel] : addr_arr[rd_sel];
   assign stop_before = |hit;

   // R7: the reserved privilege code never stops an access
   p_rsvd_priv_r7: assert property (@(posedge clk) disable iff (rst)
      (acc_priv == 2'd3) |-> !stop_before);
   // R9: the stop request follows the hit vector in the same cycle
   p_stop_hit_r9: assert property (@(posedge clk) disable iff (rst)
      (hit != '0) |-> stop_before);
   // R1: registers read zero in the cycle after reset
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (rd_data == '0));

endmodule

// File: tb/tb_dwatch_cmp.sv
module tb_dwatch_cmp;

   localparam int ADDR_W = 64;
   localparam int NUM_CH = 2;
   localparam int SIZE_W = 4;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              wr_en = 1'b0;
   logic [0:0]        wr_sel = '0;
   logic              wr_ctrl = 1'b0;
   logic [ADDR_W-1:0] wr_data = '0;
   logic [0:0]        rd_sel = '0;
   logic              rd_ctrl = 1'b0;
   logic [ADDR_W-1:0] rd_data;
   logic              acc_valid = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [SIZE_W-1:0] acc_size = '0;
   logic              acc_write = 1'b0;
   logic [1:0]        acc_priv = '0;
   logic [NUM_CH-1:0] hit;
   logic              stop_before;

   int n_checks = 0;
   int n_fail   = 0;
   logic [63:0] m_addr [NUM_CH];
   logic [63:0] m_ctrl [NUM_CH];

   dwatch_cmp #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SIZE_W(SIZE_W)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ctrl(wr_ctrl),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_ctrl(rd_ctrl), .rd_data(rd_data),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
      .acc_write(acc_write), .acc_priv(acc_priv), .hit(hit),
      .stop_before(stop_before));

   always #5ns clk = ~clk;

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Model built from the requirements
   function automatic bit exp_hit(int ch, logic [63:0] a, logic [3:0] sz,
                                  bit wr, logic [1:0] pv, bit v);
      logic [64:0] b, len;
      bit ov, dir, pok;
      b   = {1'b0, m_addr[ch][63:3], 3'b000};
      len = (65'(m_ctrl[ch][15:10]) + 65'd1) * 65'd8;
      ov  = (sz != 0) && ({1'b0, a} < b + len) && (b < {1'b0, a} + 65'(sz));
      dir = wr ? m_ctrl[ch][6] : m_ctrl[ch][5];
      case (pv)
         2'd0: pok = m_ctrl[ch][0];
         2'd1: pok = m_ctrl[ch][1];
         2'd2: pok = m_ctrl[ch][2];
         default: pok = 1'b0;
      endcase
      return v && ov && dir && pok;
   endfunction

   task automatic reg_write(int ch, bit ctl, logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'(ch); wr_ctrl = ctl; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (ctl) m_ctrl[ch] = d; else m_addr[ch] = d;
   endtask

   task automatic reg_read_chk(string req, int ch, bit ctl);
      rd_sel = 1'(ch); rd_ctrl = ctl;
      #1ns;
      check(req, rd_data, ctl ? m_ctrl[ch] : m_addr[ch]);
   endtask

   task automatic access(string req, logic [63:0] a, logic [3:0] sz,
                         bit wr, logic [1:0] pv, bit v);
      logic [1:0] e;
      acc_valid = v; acc_addr = a; acc_size = sz; acc_write = wr; acc_priv = pv;
      #1ns;
      for (int c = 0; c < NUM_CH; c++) e[c] = exp_hit(c, a, sz, wr, pv, v);
      check(req, 64'(hit), 64'(e));
      check(req, 64'(stop_before), 64'(|e));
   endtask

   // Control word: count, read/write enables, privilege enables, spare bit 7
   function automatic logic [63:0] mk_ctrl(int cnt, bit rd, bit wr,
                                           bit pr, bit sv, bit hv, bit spare);
      logic [63:0] r = '0;
      r[15:10] = 6'(cnt); r[5] = rd; r[6] = wr;
      r[0] = pr; r[1] = sv; r[2] = hv; r[7] = spare;
      return r;
   endfunction

   initial begin
      for (int c = 0; c < NUM_CH; c++) begin m_addr[c] = '0; m_ctrl[c] = '0; end
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R1: reset state
      for (int c = 0; c < NUM_CH; c++) begin
         reg_read_chk("R1 addr", c, 1'b0);
         reg_read_chk("R1 ctrl", c, 1'b1);
      end
      access("R1 no hit", 64'h0, 4'd8, 1'b0, 2'd0, 1'b1);

      // R2/R3/R4: base 0x1000 (low bits 5 ignored), 16-byte window
      reg_write(0, 1'b0, 64'h1005);
      reg_write(0, 1'b1, mk_ctrl(1, 1, 1, 1, 1, 1, 0));
      reg_read_chk("R2 addr readback", 0, 1'b0);
      reg_read_chk("R2 ctrl readback", 0, 1'b1);
      reg_read_chk("R2 other channel", 1, 1'b1);
      access("R3 first byte", 64'h1000, 4'd1, 1'b0, 2'd0, 1'b1);
      access("R4 last byte", 64'h100F, 4'd1, 1'b0, 2'd0, 1'b1);
      access("R4 past end", 64'h1010, 4'd1, 1'b0, 2'd0, 1'b1);
      access("R5 straddle", 64'h0FFF, 4'd2, 1'b1, 2'd1, 1'b1);
      access("R5 below", 64'h0FFF, 4'd1, 1'b1, 2'd1, 1'b1);
      access("R5 zero size", 64'h1000, 4'd0, 1'b0, 2'd0, 1'b1);
      access("R9 not valid", 64'h1000, 4'd8, 1'b0, 2'd0, 1'b0);

      // R6: reads only, then writes only, then neither
      reg_write(0, 1'b1, mk_ctrl(1, 1, 0, 1, 1, 1, 0));
      access("R6 read enabled", 64'h1008, 4'd4, 1'b0, 2'd2, 1'b1);
      access("R6 write disabled", 64'h1008, 4'd4, 1'b1, 2'd2, 1'b1);
      reg_write(0, 1'b1, mk_ctrl(1, 0, 1, 1, 1, 1, 0));
      access("R6 write enabled", 64'h1008, 4'd4, 1'b1, 2'd2, 1'b1);
      access("R6 read disabled", 64'h1008, 4'd4, 1'b0, 2'd2, 1'b1);
      reg_write(0, 1'b1, mk_ctrl(1, 0, 0, 1, 1, 1, 0));
      access("R6 both clear", 64'h1008, 4'd4, 1'b1, 2'd0, 1'b1);

      // R7: supervisor only, then no privilege
      reg_write(0, 1'b1, mk_ctrl(1, 1, 1, 0, 1, 0, 0));
      for (int p = 0; p < 4; p++)
         access("R7 supervisor only", 64'h1004, 4'd2, 1'b0, 2'(p), 1'b1);
      reg_write(0, 1'b1, mk_ctrl(1, 1, 1, 0, 0, 0, 0));
      access("R7 none enabled", 64'h1004, 4'd2, 1'b0, 2'd1, 1'b1);

      // R8: spare bit stored, no effect
      reg_write(0, 1'b1, mk_ctrl(1, 1, 1, 1, 1, 1, 1));
      reg_read_chk("R8 spare readback", 0, 1'b1);
      access("R8 spare no effect", 64'h100F, 4'd1, 1'b0, 2'd0, 1'b1);
      access("R8 spare no effect out", 64'h1010, 4'd1, 1'b0, 2'd0, 1'b1);

      // R10: move the window; old address must stop matching at once
      reg_write(0, 1'b0, 64'h2000);
      access("R10 old window", 64'h1000, 4'd8, 1'b0, 2'd0, 1'b1);
      access("R10 new window", 64'h2008, 4'd8, 1'b0, 2'd0, 1'b1);

      // R5: window at the top of the address space, no wrap
      reg_write(1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      reg_write(1, 1'b1, mk_ctrl(0, 1, 1, 1, 1, 1, 0));
      access("R5 top byte", 64'hFFFF_FFFF_FFFF_FFFF, 4'd1, 1'b0, 2'd0, 1'b1);
      access("R5 no wrap", 64'h0, 4'd8, 1'b0, 2'd0, 1'b1);
      access("R5 access crosses top", 64'hFFFF_FFFF_FFFF_FFF0, 4'd15, 1'b1, 2'd2, 1'b1);

      // Random mix of rewrites and near-window accesses (R9, R10)
      for (int i = 0; i < 4000; i++) begin
         int ch = $urandom_range(0, NUM_CH - 1);
         if ($urandom_range(0, 9) < 2) begin
            if ($urandom_range(0, 1) == 1)
               reg_write(ch, 1'b1, {$urandom, $urandom});
            else
               reg_write(ch, 1'b0, {$urandom, $urandom});
         end else begin
            logic [63:0] a;
            a = {m_addr[ch][63:3], 3'b000} + 64'($urandom_range(0, 560)) - 64'd16;
            @(negedge clk);
            access("R9 random", a, 4'($urandom_range(0, 15)), 1'($urandom),
                   2'($urandom), ($urandom_range(0, 15) != 0));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule